// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Compare

This combinational unit takes two operands and a 3-bit operation code and returns a result word plus carry, zero and overflow flags. It performs bitwise AND, bitwise OR, addition, subtraction and a signed less-than compare. The compare returns 1 or 0 in bit 0 of the result. The datapath is a row of identical one-bit slices joined by a ripple carry.

Addition and subtraction share one adder. The top opcode bit inverts the B operand in every slice and also supplies the carry into bit 0. The compare runs a subtraction alongside. A separate sign unit then forms the less-than bit from the signs of A, B and the difference, so the answer stays correct when the difference overflows. That bit enters only the lowest slice. The upper slices see a constant 0 on their less-than input.

Top module: `alu_core`

## Requirements
- R1: Opcode 000 gives `result_o = a_i & b_i`.
- R2: Opcode 001 gives `result_o = a_i | b_i`.
- R3: Opcode 010 gives `result_o = a_i + b_i` modulo 2^32, and `carry_o` is the carry out of bit 31.
- R4: Opcode 110 gives `result_o = a_i - b_i` modulo 2^32, computed as `a_i + ~b_i + 1`. `carry_o` is the carry out of bit 31 of that sum, so it is 1 exactly when `a_i >= b_i` as unsigned numbers.
- R5: Opcode 111 sets bits 31:1 of `result_o` to 0. Bit 0 is 1 exactly when `a_i < b_i` as two's-complement numbers, including operand pairs whose difference overflows.
- R6: For opcode 010, `overflow_o` is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R7: For opcode 110, `overflow_o` is 1 exactly when the operand sign bits differ and the result's sign bit differs from the sign bit of `a_i`.
- R8: For opcodes 000, 001 and 111, `overflow_o` and `carry_o` are both 0.
- R9: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0.
- R10: Opcodes 011, 100 and 101 give `result_o = 0`, `carry_o = 0`, `overflow_o = 0` and `zero_o = 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | Carry out of the top adder bit |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The unit holds no state, so any fault shows at the ports in the same evaluation as the inputs that expose it.

- A broken carry link or a wrong B-invert changes add and subtract results only for operands whose carries cross the faulty position. The vector set therefore includes all-ones, sign-boundary and alternating-bit operands.
- A compare that reads only the difference sign gives the wrong answer only when signs differ and the difference overflows. The INT_MIN and INT_MAX pairs target exactly that case.
- Flag gating faults show only on non-arithmetic or unlisted opcodes. For that reason every operand pair is run under all eight codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // slice output multiplexer select (low opcode bits)
  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       cout_o
);
  logic b_eff, sum;

  assign b_eff  = b_i ^ binv_i;
  assign sum    = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND: res_o = a_i & b_i;
      SEL_OR:  res_o = a_i | b_i;
      SEL_SUM: res_o = sum;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_less_unit.sv
module alu_less_unit (
  input  logic a_sign_i,
  input  logic b_sign_i,
  input  logic diff_sign_i,
  output logic less_o
);
  // mixed signs decide directly; equal signs cannot overflow
  assign less_o = (a_sign_i ^ b_sign_i) ? a_sign_i : diff_sign_i;
endmodule

// File: rtl/alu_ovf_unit.sv
module alu_ovf_unit (
  input  logic sub_i,
  input  logic a_sign_i,
  input  logic b_sign_i,
  input  logic r_sign_i,
  output logic ovf_o
);
  logic b_eff_sign;

  assign b_eff_sign = b_sign_i ^ sub_i;
  assign ovf_o      = (a_sign_i == b_eff_sign) && (r_sign_i != a_sign_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             overflow_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] slice_res;
  logic             binv;
  logic             less;
  logic             sum_msb;
  logic             ovf_raw;
  logic             op_valid;
  logic             op_arith;

  assign binv     = op_i[2];
  assign carry[0] = binv;

  assign op_valid = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_ADD) ||
                    (op_i == OP_SUB) || (op_i == OP_SLT);
  assign op_arith = (op_i == OP_ADD) || (op_i == OP_SUB);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less;
    end else begin : g_upper
      assign less_in = 1'b0;
    end
    alu_bit_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .binv_i (binv),
      .cin_i  (carry[i]),
      .less_i (less_in),
      .sel_i  (op_i[1:0]),
      .res_o  (slice_res[i]),
      .cout_o (carry[i+1])
    );
  end

  // sign of the adder output, independent of the slice mux
  assign sum_msb = a_i[MSB] ^ b_i[MSB] ^ binv ^ carry[MSB];

  alu_less_unit u_less (
    .a_sign_i    (a_i[MSB]),
    .b_sign_i    (b_i[MSB]),
    .diff_sign_i (sum_msb),
    .less_o      (less)
  );

  alu_ovf_unit u_ovf (
    .sub_i    (binv),
    .a_sign_i (a_i[MSB]),
    .b_sign_i (b_i[MSB]),
    .r_sign_i (sum_msb),
    .ovf_o    (ovf_raw)
  );

  assign result_o   = op_valid ? slice_res : '0;
  assign carry_o    = op_arith & carry[WIDTH];
  assign overflow_o = op_arith & ovf_raw;
  assign zero_o     = ~|result_o;
endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             zero_o,
  input logic             overflow_o
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    p_zero_flag_r9: assert (zero_o == (result_o == '0))
      else $error("zero flag disagrees with result");
    if (op_i == OP_SLT) begin
      p_slt_upper_r5: assert (result_o[MSB:1] == '0)
        else $error("compare set upper bits");
      if (a_i[MSB] != b_i[MSB]) begin
        p_slt_mixed_r5: assert (result_o[0] == a_i[MSB])
          else $error("mixed-sign compare wrong");
      end
    end
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT) begin
      p_no_overflow_r8: assert (!overflow_o && !carry_o)
        else $error("flags set on non-arithmetic op");
    end
    if (op_i == OP_ADD) begin
      p_add_ovf_r6: assert (overflow_o ==
          ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
        else $error("add overflow wrong");
    end
    if (op_i == OP_SUB) begin
      p_sub_ovf_r7: assert (overflow_o ==
          ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
        else $error("sub overflow wrong");
    end
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
      p_unlisted_r10: assert (result_o == '0 && zero_o && !carry_o && !overflow_o)
        else $error("unlisted opcode not quiet");
    end
  end
endmodule

bind alu_core alu_core_checker #(.WIDTH(WIDTH)) u_alu_core_checker (
  .a_i        (a_i),
  .b_i        (b_i),
  .op_i       (op_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .zero_o     (zero_o),
  .overflow_o (overflow_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
  localparam int W = 32;
  localparam int NPAIR = 12;
  localparam logic [63:0] PAIRS [NPAIR] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'hffff_ffff, 32'h0000_0001},
    {32'h7fff_ffff, 32'h0000_0001},
    {32'h8000_0000, 32'h8000_0000},
    {32'h8000_0000, 32'h0000_0001},
    {32'h7fff_ffff, 32'hffff_ffff},
    {32'h1234_5678, 32'h1234_5678},
    {32'h0000_0005, 32'h0000_0009},
    {32'hffff_fff0, 32'h0000_0003},
    {32'h8000_0000, 32'h7fff_ffff},
    {32'h0000_0001, 32'h8000_0000},
    {32'ha5a5_a5a5, 32'h5a5a_5a5a}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b, res;
  logic [2:0] op;
  logic carry, zero, ovf;
  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  alu_core #(.WIDTH(W)) u_alu_core (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .carry_o(carry), .zero_o(zero), .overflow_o(ovf)
  );

  // behavioural model: returns {result, carry, zero, overflow}
  function automatic logic [W+2:0] model(input logic [2:0] o,
                                         input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    logic c, v;
    logic [W:0] u;
    longint sx, sy, s;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    r = '0; c = 1'b0; v = 1'b0;
    case (o)
      3'b000: r = x & y;
      3'b001: r = x | y;
      3'b010: begin
        u = {1'b0, x} + {1'b0, y};
        r = u[W-1:0]; c = u[W];
        s = sx + sy;
        v = (s > 64'sh7fff_ffff) || (s < -64'sh8000_0000);
      end
      3'b110: begin
        r = x - y; c = (x >= y);
        s = sx - sy;
        v = (s > 64'sh7fff_ffff) || (s < -64'sh8000_0000);
      end
      3'b111: r = {{(W-1){1'b0}}, (sx < sy)};
      default: r = '0;
    endcase
    return {r, c, (r == '0), v};
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'b000: return "R1 R8 R9";
      3'b001: return "R2 R8 R9";
      3'b010: return "R3 R6 R9";
      3'b110: return "R4 R7 R9";
      3'b111: return "R5 R8 R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply_check(input logic [2:0] o, input logic [W-1:0] x,
                             input logic [W-1:0] y, input string req);
    logic [W+2:0] exp, act;
    @(negedge clk);
    op = o; a = x; b = y;
    #2;
    exp = model(o, x, y);
    act = {res, carry, zero, ovf};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual={res %h c %b z %b v %b} expected={res %h c %b z %b v %b}",
               req, o, x, y, act[W+2:3], act[2], act[1], act[0],
               exp[W+2:3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: zero operands, AND -> zero result, Zero flag set (R9)
    apply_check(3'b000, '0, '0, "R9 idle");
    for (int p = 0; p < NPAIR; p++) begin
      for (int o = 0; o < 8; o++) begin
        apply_check(3'(o), PAIRS[p][63:32], PAIRS[p][31:0], tag(3'(o)));
      end
    end
    // directed corners
    apply_check(3'b010, 32'h7fff_ffff, 32'h7fff_ffff, "R6 pos+pos");
    apply_check(3'b010, 32'h8000_0000, 32'hffff_ffff, "R6 neg+neg");
    apply_check(3'b110, 32'h8000_0000, 32'h0000_0001, "R7 neg-pos");
    apply_check(3'b110, 32'h7fff_ffff, 32'h8000_0000, "R7 pos-neg");
    apply_check(3'b111, 32'h7fff_ffff, 32'h8000_0000, "R5 max vs min");
    apply_check(3'b111, 32'h8000_0000, 32'h7fff_ffff, "R5 min vs max");
    apply_check(3'b111, 32'hffff_ffff, 32'hffff_ffff, "R5 equal");
    apply_check(3'b110, 32'hdead_beef, 32'hdead_beef, "R9 R4 self-sub");
    apply_check(3'b010, 32'hffff_ffff, 32'h0000_0001, "R3 carry wrap");
    apply_check(3'b100, 32'hffff_ffff, 32'hffff_ffff, "R10 op100");
    apply_check(3'b101, 32'h0f0f_0f0f, 32'hf0f0_f0f0, "R10 op101");
    apply_check(3'b011, 32'h8000_0000, 32'h0000_0001, "R10 op011");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule